// File: doc/BRIEF.md
# Channel-Rotating State Register File

This block stores the working state of a multi-channel signal-processing datapath. The datapath handles `NCH` channels, and each channel keeps `NST` state words. That makes `NCH*NST` registers in total. At any moment the arithmetic unit sees only the `NST` words of a single channel, the active one. Both the read port and the write port address a word by its state index alone. No port ever offers a full random address over every register.

A single strobe moves the datapath from one channel to the next. On that strobe the storage rotates like a circular shift, so the next channel's words arrive in the access slot. The channel number counts up and wraps back to zero. Write data is broadcast to every word. A word captures it only when its per-state enable is set, and there are `NST` such enables, one per state index. Those enables stand in for clock-gating cells. Because only `NST` words are visible, the read multiplexer has `NST` inputs.

Top module: `chan_serial_rf`

## Requirements
- R1: While `rst_n` is low, and after it is released, every stored word reads 0 and `chan_o` is 0.
- R2: With `wr_en_i` high, `adv_i` low and `wr_idx_i` below `NST`, the active channel's word at state `wr_idx_i` holds `wr_data_i` from the next cycle on.
- R3: `rd_data_o` shows the active channel's word at state `rd_sel_i` in the same cycle, with no register on the read path.
- R4: Each cycle with `adv_i` high adds 1 to `chan_o`, going from `NCH-1` back to 0. `chan_o` holds its value in every other cycle.
- R5: Rotation loses nothing. After `NCH` advances the same channel is active again and all its words are intact.
- R6: When a write and an advance fall in the same cycle, the write goes into the channel that is leaving the access slot.
- R7: In a cycle with `wr_en_i` low, no stored word changes, whatever `wr_idx_i` and `wr_data_i` carry.
- R8: A state index of `NST` or above (value 3 with the default `NST`=3) selects nothing. A write to it changes no word, and a read of it returns 0.
- R9: A write changes only the addressed state of the active channel. The other states of that channel and all other channels keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Advance strobe: rotate to the next channel |
| rd_sel_i | input | SW | State index read from the active channel |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | SW | State index written in the active channel |
| wr_data_i | input | W | Write data, broadcast to all words |
| rd_data_o | output | W | Selected word of the active channel |
| chan_o | output | CW | Number of the active channel |

## Verification
The assertions take it that every input is a defined 0 or 1 on each rising edge. They also take it that `adv_i` and `wr_en_i` are low on the edge where reset is released. Since the antecedents look one cycle back, the checks that involve the past skip the first cycle after reset. The bench changes inputs only on falling edges and holds them low throughout reset. It deliberately drives an out-of-range index with `wr_en_i` high, to check that such a write has no effect.

// File: rtl/chan_serial_rf.sv
module chan_serial_rf #(
  parameter  int NCH = 4,
  parameter  int NST = 3,
  parameter  int W   = 16,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW  = (NST > 1) ? $clog2(NST) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic [SW-1:0] rd_sel_i,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  rd_data_o,
  output logic [CW-1:0] chan_o
);

  logic [NCH-1:0][NST-1:0][W-1:0] ring;
  logic [NCH-1:0][NST-1:0][W-1:0] adv_src;
  logic [NCH-1:0][NST-1:0][W-1:0] stay_src;
  logic [NST-1:0]                 wen;
  logic [NST-1:0][W-1:0]          front_nx;
  logic [CW-1:0]                  chan;

  for (genvar s = 0; s < NST; s++) begin : g_state
    assign wen[s]      = wr_en_i && (wr_idx_i == SW'(s));
    assign front_nx[s] = wen[s] ? wr_data_i : ring[0][s];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    if (c == NCH - 1) begin : g_tail
      assign adv_src[c] = front_nx;
    end else begin : g_mid
      assign adv_src[c] = ring[c+1];
    end
    if (c == 0) begin : g_head
      assign stay_src[c] = front_nx;
    end else begin : g_rest
      assign stay_src[c] = ring[c];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)     ring[c] <= '0;
      else if (adv_i) ring[c] <= adv_src[c];
      else            ring[c] <= stay_src[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     chan <= '0;
    else if (adv_i) chan <= (chan == CW'(NCH - 1)) ? '0 : chan + 1'b1;
  end

  assign chan_o    = chan;
  assign rd_data_o = (int'(rd_sel_i) < NST) ? ring[0][rd_sel_i] : '0;

  assert_chan_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(adv_i) |->
      chan_o == (($past(chan_o) == CW'(NCH - 1)) ? '0 : $past(chan_o) + 1'b1));

  assert_chan_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(adv_i) |-> $stable(chan_o));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_en_i) && !$past(adv_i) && (int'($past(wr_idx_i)) < NST) |->
      ring[0][$past(wr_idx_i)] == $past(wr_data_i));

  assert_write_outgoing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_en_i) && $past(adv_i) && (int'($past(wr_idx_i)) < NST) |->
      ring[NCH-1][$past(wr_idx_i)] == $past(wr_data_i));

  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(wr_en_i) && !$past(adv_i) |-> $stable(ring));

  assert_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(adv_i) && !$past(wr_en_i) |-> ring[NCH-1] == $past(ring[0]));

  assert_oob_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(adv_i) && (int'($past(wr_idx_i)) >= NST) |-> $stable(ring));

  assert_one_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wen));

endmodule

// File: tb/chan_serial_rf_tb.sv
module chan_serial_rf_tb;
  localparam int NCH = 4, NST = 3, W = 16, CW = 2, SW = 2, NV = 15;

  logic clk = 0, rst_n = 0, adv = 0, we = 0;
  logic [SW-1:0] rsel = 0, widx = 0;
  logic [W-1:0]  wdata = 0, rdata;
  logic [CW-1:0] chan;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chan_serial_rf #(.NCH(NCH), .NST(NST), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .rd_sel_i(rsel), .wr_en_i(we),
    .wr_idx_i(widx), .wr_data_i(wdata), .rd_data_o(rdata), .chan_o(chan));

  // {adv, we, widx, wdata, rsel, expected rdata, expected chan}; outputs checked before the edge
  localparam logic [39:0] VEC [NV] = '{
    {1'b0,1'b1,2'd0,16'h1111,2'd0,16'h0000,2'd0},
    {1'b0,1'b1,2'd1,16'h2222,2'd0,16'h1111,2'd0},
    {1'b0,1'b0,2'd0,16'h0000,2'd1,16'h2222,2'd0},
    {1'b1,1'b1,2'd2,16'h3333,2'd2,16'h0000,2'd0},
    {1'b0,1'b1,2'd0,16'hAAAA,2'd0,16'h0000,2'd1},
    {1'b1,1'b0,2'd0,16'h0000,2'd0,16'hAAAA,2'd1},
    {1'b0,1'b1,2'd1,16'hBBBB,2'd1,16'h0000,2'd2},
    {1'b1,1'b0,2'd0,16'h0000,2'd1,16'hBBBB,2'd2},
    {1'b0,1'b1,2'd0,16'h4444,2'd3,16'h0000,2'd3},
    {1'b1,1'b1,2'd3,16'hDEAD,2'd0,16'h4444,2'd3},
    {1'b0,1'b0,2'd0,16'h0000,2'd2,16'h3333,2'd0},
    {1'b0,1'b0,2'd0,16'hFFFF,2'd0,16'h1111,2'd0},
    {1'b0,1'b0,2'd2,16'h5555,2'd1,16'h2222,2'd0},
    {1'b0,1'b0,2'd0,16'h0000,2'd0,16'h1111,2'd0},
    {1'b0,1'b0,2'd0,16'h0000,2'd2,16'h3333,2'd0}
  };

  function automatic string vtag(int i);
    case (i)
      0, 4:     return "R1";
      1, 2, 6:  return "R2";
      3, 10:    return "R6";
      5, 7:     return "R4";
      8:        return "R8";
      9:        return "R5";
      11, 12:   return "R7";
      13:       return "R9";
      default:  return "R3";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic a, logic e, logic [SW-1:0] wi, logic [W-1:0] wd, logic [SW-1:0] rs);
    @(negedge clk);
    adv = a; we = e; widx = wi; wdata = wd; rsel = rs;
    #1;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "chan in reset", W'(chan), 16'h0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][39], VEC[i][38], VEC[i][37:36], VEC[i][35:20], VEC[i][19:18]);
      chk(vtag(i), $sformatf("vec %0d rdata", i), rdata, VEC[i][17:2]);
      chk("R4", $sformatf("vec %0d chan", i), W'(chan), W'(VEC[i][1:0]));
    end
    // R8/R9: visit channel 3, out-of-range write left its words alone
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R4", "chan after 3 advances", W'(chan), 16'd3);
    chk("R9", "ch3 s0", rdata, 16'h4444);
    step(0, 0, 0, 0, 1); chk("R8", "ch3 s1 untouched", rdata, 16'h0);
    step(0, 0, 0, 0, 2); chk("R8", "ch3 s2 untouched", rdata, 16'h0);
    // R5: ch1 and ch2 intact after rotation
    step(1, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    chk("R4", "wrap to 0", W'(chan), 16'd0);
    step(1, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    chk("R5", "ch1 s0 kept", rdata, 16'hAAAA);
    step(1, 0, 0, 0, 1); step(0, 0, 0, 0, 1);
    chk("R5", "ch2 s1 kept", rdata, 16'hBBBB);
    chk("R3", "chan 2", W'(chan), 16'd2);
    // R3: read select changes same cycle
    step(0, 0, 0, 0, 0); chk("R3", "ch2 s0 zero", rdata, 16'h0);
    // R1: reset mid-run
    @(negedge clk); rst_n = 0; adv = 0; we = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    chk("R1", "chan after reset", W'(chan), 16'h0);
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < NST; s++) begin
        step(0, 0, 0, 0, SW'(s));
        chk("R1", $sformatf("ch%0d s%0d cleared", c, s), rdata, 16'h0);
      end
      step(1, 0, 0, 0, 0);
    end
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule